// File: doc/BRIEF.md
# Bidirectional Port with Peripheral Overrides

This block is an eight-pin general-purpose I/O port that sits on a CPU register bus. Software sets a direction bit per pin and writes an output value. Reading the port returns the stored value for pins set as outputs and the synchronized pad level for pins set as inputs. For each pin the block drives an output value and an output-enable to the pad ring.

Two on-chip functions can take pins away from software. When the serial peripheral interface is enabled, the upper three pins carry its MISO, MOSI and SCK lines. A master/slave input then sets which of them are driven. When the clock-output function is enabled, pin 2 carries the internal system clock whatever its direction bit says. Data bit 2 is then cleared and cannot be reached. The SPI engine and the clock source are outside the block and drive its override inputs.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is asserted, every direction bit is cleared, so all eight pins have output-enable low. Reset does not clear the data register.
- R2: A bus write to address 0x1 loads the data register. A pin whose direction bit is 1 drives the stored bit on its output, and a read of address 0x1 returns that stored bit.
- R3: Address 0x5 holds the direction register, with bit n belonging to pin n. A direction bit of 1 raises that pin's output-enable, and a bit of 0 lowers it. A read of 0x5 returns the direction register.
- R4: For a pin whose direction bit is 0, a read of address 0x1 returns the pad level after a two-flop synchronizer. A pad change becomes visible after two rising clock edges and not after one.
- R5: With SPI enabled and master selected, pin 5 (MISO) is an input. Pin 6 (MOSI) and pin 7 (SCK) are outputs driven from the peripheral's MOSI and SCK signals. Direction bits 5 to 7 have no effect.
- R6: With SPI enabled and slave selected, pin 5 is an output driven from the peripheral's MISO signal, and pins 6 and 7 are inputs. Direction bits 5 to 7 have no effect.
- R7: The raw pad levels of pins 5, 6 and 7 are always passed back to the peripheral on its MISO, MOSI and SCK inputs.
- R8: With the clock output enabled, pin 2 has output-enable high and drives the system clock input, whatever direction bit 2 holds. The other pins are unaffected.
- R9: With the clock output enabled, all eight bits of the direction register can still be written and read back.
- R10: With the clock output enabled, data bit 2 reads as 0, ignores writes and is cleared, so it still reads 0 after the clock output is turned off.
- R11: Bus addresses other than 0x1 and 0x5 read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| spi_en | input | 1 | Serial peripheral owns pins 5 to 7 |
| spi_master | input | 1 | 1 = master, 0 = slave |
| spi_miso_drv | input | 1 | MISO value from the peripheral (slave mode) |
| spi_mosi_drv | input | 1 | MOSI value from the peripheral (master mode) |
| spi_sck_drv | input | 1 | SCK value from the peripheral (master mode) |
| spi_miso_rx | output | 1 | Pad level of pin 5 to the peripheral |
| spi_mosi_rx | output | 1 | Pad level of pin 6 to the peripheral |
| spi_sck_rx | output | 1 | Pad level of pin 7 to the peripheral |
| clkout_en | input | 1 | System clock owns pin 2 |
| sys_clk_val | input | 1 | System clock value to drive on pin 2 |

## Verification
The bench sweeps all 256 data values with every pin set as output, and all 256 direction patterns against fixed data and pad values. This catches a swapped or inverted direction sense and a read mux that returns the wrong source for a pin. The synchronizer is sampled after one edge and after two, so a design missing a flop or with one flop too many shows the new level at the wrong time. The SPI overrides are checked in both roles with direction bits all 0 and all 1. A design that let direction bits leak through, or that swapped the master and slave drive, would show the wrong output-enable on pins 5 to 7. For the clock-output case, bit 2 is written while the function is on and then read after it is turned off. A design that only masked the read, without clearing the stored bit, would read back 1 there.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 4;

    typedef struct packed {
        logic [PORT_W-1:0] dat;
        logic [PORT_W-1:0] dir;
    } port_state_t;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    // R4: the output follows the input two edges late
    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (sync_out == $past(async_in, STAGES)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int CLK_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dat,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    input  logic             clkout_en,
    output logic [WIDTH-1:0] dat_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] dat_d;
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] keep_mask;

    always_comb begin
        keep_mask          = '1;
        keep_mask[CLK_PIN] = !clkout_en;
        dat_d = wr_dat ? wdata : dat_q;
        dat_d = dat_d & keep_mask;
        dir_d = wr_dir ? wdata : dir_q;
    end

    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    assert_dir_cleared_R1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0));
    assert_dat_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !clkout_en) |=> (dat_q == $past(wdata)));
    assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wdata)));
    assert_clk_bit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_en |=> (dat_q[CLK_PIN] == 1'b0));
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
    parameter int WIDTH    = 8,
    parameter int CLK_PIN  = 2,
    parameter int MISO_PIN = 5,
    parameter int MOSI_PIN = 6,
    parameter int SCK_PIN  = 7
) (
    input  logic [WIDTH-1:0] dat_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pad_sync,
    input  logic [WIDTH-1:0] pad_raw,
    input  logic             spi_en,
    input  logic             spi_master,
    input  logic             spi_miso_drv,
    input  logic             spi_mosi_drv,
    input  logic             spi_sck_drv,
    input  logic             clkout_en,
    input  logic             sys_clk_val,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] port_rd,
    output logic             spi_miso_rx,
    output logic             spi_mosi_rx,
    output logic             spi_sck_rx
);
    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            logic out_d, oe_d, rd_d;
            always_comb begin
                out_d = dat_q[p];
                oe_d  = dir_q[p];
                rd_d  = dir_q[p] ? dat_q[p] : pad_sync[p];
                if (p == CLK_PIN) begin
                    if (clkout_en) begin
                        out_d = sys_clk_val;
                        oe_d  = 1'b1;
                        rd_d  = 1'b0;
                    end
                end else if (p == MISO_PIN) begin
                    if (spi_en) begin
                        out_d = spi_miso_drv;
                        oe_d  = !spi_master;
                    end
                end else if (p == MOSI_PIN) begin
                    if (spi_en) begin
                        out_d = spi_mosi_drv;
                        oe_d  = spi_master;
                    end
                end else if (p == SCK_PIN) begin
                    if (spi_en) begin
                        out_d = spi_sck_drv;
                        oe_d  = spi_master;
                    end
                end
            end
            assign pin_out[p] = out_d;
            assign pin_oe[p]  = oe_d;
            assign port_rd[p] = rd_d;
        end
    endgenerate

    assign spi_miso_rx = pad_raw[MISO_PIN];
    assign spi_mosi_rx = pad_raw[MOSI_PIN];
    assign spi_sck_rx  = pad_raw[SCK_PIN];
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_port_pkg::*;
#(
    parameter int WIDTH     = PORT_W,
    parameter int AW        = ADDR_W,
    parameter int DAT_ADDR  = 1,
    parameter int DIR_ADDR  = 5,
    parameter int SYNC_STG  = 2,
    parameter int CLK_PIN   = 2,
    parameter int MISO_PIN  = 5,
    parameter int MOSI_PIN  = 6,
    parameter int SCK_PIN   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    input  logic             spi_en,
    input  logic             spi_master,
    input  logic             spi_miso_drv,
    input  logic             spi_mosi_drv,
    input  logic             spi_sck_drv,
    output logic             spi_miso_rx,
    output logic             spi_mosi_rx,
    output logic             spi_sck_rx,
    input  logic             clkout_en,
    input  logic             sys_clk_val
);
    localparam logic [AW-1:0] DAT_A = AW'(DAT_ADDR);
    localparam logic [AW-1:0] DIR_A = AW'(DIR_ADDR);

    logic             hit_dat, hit_dir;
    logic [WIDTH-1:0] dat_q, dir_q, pad_sync, port_rd;

    assign hit_dat = (bus_addr == DAT_A);
    assign hit_dir = (bus_addr == DIR_A);

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pad_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH), .CLK_PIN(CLK_PIN)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dat(bus_wr && hit_dat), .wr_dir(bus_wr && hit_dir),
        .wdata(bus_wdata), .clkout_en(clkout_en),
        .dat_q(dat_q), .dir_q(dir_q)
    );

    gpio_port_mux #(.WIDTH(WIDTH), .CLK_PIN(CLK_PIN), .MISO_PIN(MISO_PIN),
                    .MOSI_PIN(MOSI_PIN), .SCK_PIN(SCK_PIN)) u_mux (
        .dat_q(dat_q), .dir_q(dir_q), .pad_sync(pad_sync), .pad_raw(pin_in),
        .spi_en(spi_en), .spi_master(spi_master),
        .spi_miso_drv(spi_miso_drv), .spi_mosi_drv(spi_mosi_drv),
        .spi_sck_drv(spi_sck_drv), .clkout_en(clkout_en),
        .sys_clk_val(sys_clk_val), .pin_out(pin_out), .pin_oe(pin_oe),
        .port_rd(port_rd), .spi_miso_rx(spi_miso_rx),
        .spi_mosi_rx(spi_mosi_rx), .spi_sck_rx(spi_sck_rx)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_dat)      bus_rdata = port_rd;
        else if (hit_dir) bus_rdata = dir_q;
    end

    assert_clk_pin_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_en |-> (pin_oe[CLK_PIN] && pin_out[CLK_PIN] == sys_clk_val));
    assert_spi_master_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> (!pin_oe[MISO_PIN] && pin_oe[MOSI_PIN] && pin_oe[SCK_PIN]));
    assert_spi_slave_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (pin_oe[MISO_PIN] && !pin_oe[MOSI_PIN] && !pin_oe[SCK_PIN]));
    assert_clk_bit_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clkout_en && hit_dat) |-> (bus_rdata[CLK_PIN] == 1'b0));
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_dat && !hit_dir) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
    logic spi_en = 0, spi_master = 0, miso_d = 0, mosi_d = 0, sck_d = 0;
    logic miso_r, mosi_r, sck_r, clkout_en = 0, sys_clk_val = 0;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    gpio_port_ovr u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .spi_en(spi_en),
        .spi_master(spi_master), .spi_miso_drv(miso_d), .spi_mosi_drv(mosi_d),
        .spi_sck_drv(sck_d), .spi_miso_rx(miso_r), .spi_mosi_rx(mosi_r),
        .spi_sck_rx(sck_r), .clkout_en(clkout_en), .sys_clk_val(sys_clk_val)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle_pads();
        @(negedge clk);
        @(negedge clk);
    endtask

    logic [7:0] v;

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", pin_oe, 8'h00);
        rst_n = 1;
        @(negedge clk);
        rd(4'h5, v); chk("R1 dir after reset", v, 8'h00);
        chk("R1 oe after reset", pin_oe, 8'h00);

        // R2: every data value with all pins outputs
        wr(4'h5, 8'hFF);
        for (int d = 0; d < 256; d++) begin
            wr(4'h1, 8'(d));
            chk("R2 pin_out", pin_out, 8'(d));
            rd(4'h1, v); chk("R2 readback", v, 8'(d));
        end

        // R1: data survives a reset pulse, direction does not
        wr(4'h1, 8'h96);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(4'h5, v); chk("R1 dir cleared", v, 8'h00);
        wr(4'h5, 8'hFF);
        rd(4'h1, v); chk("R1 data kept", v, 8'h96);

        // R3/R4: every direction pattern
        wr(4'h1, 8'hA5);
        pin_in = 8'h3C;
        settle_pads();
        for (int m = 0; m < 256; m++) begin
            wr(4'h5, 8'(m));
            chk("R3 oe", pin_oe, 8'(m));
            chk("R3 out on outputs", pin_out & 8'(m), 8'hA5 & 8'(m));
            rd(4'h5, v); chk("R3 dir readback", v, 8'(m));
            rd(4'h1, v); chk("R4 mixed read", v, (8'hA5 & 8'(m)) | (8'h3C & ~8'(m)));
        end

        // R4: synchronizer latency
        wr(4'h5, 8'h00);
        @(negedge clk); pin_in = 8'hC3;
        @(negedge clk);
        rd(4'h1, v); chk("R4 one edge old", v, 8'h3C);
        @(negedge clk);
        rd(4'h1, v); chk("R4 two edges new", v, 8'hC3);

        // R5/R6/R7: SPI both roles, direction 00 and FF
        for (int ms = 0; ms < 2; ms++) begin
            for (int dd = 0; dd < 2; dd++) begin
                wr(4'h5, dd ? 8'hFF : 8'h00);
                spi_en = 1; spi_master = ms[0];
                miso_d = 1; mosi_d = 0; sck_d = 1;
                #1;
                if (ms) begin
                    chk("R5 oe master", pin_oe, {3'b110, dd ? 5'h1F : 5'h00});
                    chk("R5 mosi/sck out", {6'b0, pin_out[7], pin_out[6]}, 8'h02);
                    mosi_d = 1; sck_d = 0; #1;
                    chk("R5 mosi/sck follow", {6'b0, pin_out[7], pin_out[6]}, 8'h01);
                end else begin
                    chk("R6 oe slave", pin_oe, {3'b001, dd ? 5'h1F : 5'h00});
                    chk("R6 miso out", {7'b0, pin_out[5]}, 8'h01);
                    miso_d = 0; #1;
                    chk("R6 miso follow", {7'b0, pin_out[5]}, 8'h00);
                end
                pin_in = 8'hA0; #1;
                chk("R7 rx", {5'b0, sck_r, mosi_r, miso_r}, 8'h05);
                pin_in = 8'h40; #1;
                chk("R7 rx", {5'b0, sck_r, mosi_r, miso_r}, 8'h02);
                spi_en = 0;
            end
        end

        // R8/R9/R10: clock output
        wr(4'h5, 8'h00);
        wr(4'h1, 8'hFF);
        clkout_en = 1;
        for (int c = 0; c < 2; c++) begin
            sys_clk_val = c[0]; #1;
            chk("R8 pin2 oe", pin_oe, 8'h04);
            chk("R8 pin2 value", {7'b0, pin_out[2]}, {7'b0, c[0]});
        end
        wr(4'h5, 8'h5A);
        rd(4'h5, v); chk("R9 dir rw", v, 8'h5A);
        chk("R8 others follow dir", pin_oe, 8'h5E);
        wr(4'h5, 8'hFF);
        rd(4'h5, v); chk("R9 dir rw ff", v, 8'hFF);
        wr(4'h1, 8'hFF);
        rd(4'h1, v); chk("R10 bit2 reads zero", v, 8'hFB);
        @(negedge clk); clkout_en = 0; #1;
        rd(4'h1, v); chk("R10 bit2 cleared", v, 8'hFB);
        chk("R10 pin2 drives zero", pin_out, 8'hFB);
        wr(4'h1, 8'h04);
        rd(4'h1, v); chk("R10 bit2 writable again", v, 8'h04);

        // R11: unmapped addresses
        wr(4'h1, 8'h69);
        wr(4'h5, 8'hF0);
        for (int a = 0; a < 16; a++) begin
            if (a == 1 || a == 5) continue;
            wr(4'(a), 8'hFF);
            rd(4'(a), v); chk("R11 unmapped reads 0", v, 8'h00);
        end
        rd(4'h5, v); chk("R11 dir untouched", v, 8'hF0);
        pin_in = 8'h00; settle_pads();
        rd(4'h1, v); chk("R11 data untouched", v, 8'h60);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule